// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block counts down an 8-bit value at one of four rates derived from a 32.768 kHz reference, and raises an active-low interrupt each time the count runs out. The reference arrives as a one-cycle enable pulse (`ref_tick`) in the system clock domain. A divider chain turns it into four step rates: 4096 Hz, 64 Hz, 1 Hz and one step per minute. Software reaches the block through a plain byte-wide register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. The port carries no stream traffic, so it has no valid/ready handshake and never stalls.

When the running count steps from 1, the block sets a sticky event flag and reloads the count from the programmed value, so it keeps running periodically. If the interrupt enable is set, `irq_n` does one of two things, chosen by a mode bit. In level mode it stays low for as long as the flag is set. In pulse mode it goes low for a fixed number of reference ticks for each event. Software acknowledges an event by writing 0 to the flag bit.

Register map (2-bit address): 0 = status (bit 0 interrupt enable, bit 2 event flag, bit 4 pulse mode), 1 = control (bit 7 run, bits 1:0 rate), 2 = reload value, 3 = current count (read only).

Top module: `tmr_countdown`

## Requirements
- R1: After reset, every register reads 0 and `irq_n` is high.
- R2: Control bit 7 starts the timer. Control bits 1:0 pick the step period in reference ticks: 0 gives TICKS_4K (default 8), 1 gives TICKS_64 (512), 2 gives TICKS_1 (32768), and 3 gives TICKS_1×SECS_PER_MIN (one minute). A write to control restarts the divider phase, and no step happens in the cycle of that write.
- R3: A write to address 2 sets both the reload value and the current count, which reads back at address 3. While running, the current count drops by one on each step.
- R4: A step taken while the current count is 1 sets the flag (status bit 2) and reloads the count. Programming N gives one event every N steps. A count of 0 stays at 0 and produces no events.
- R5: Writing 0 to status bit 2 clears the flag, and writing 1 leaves it unchanged. An event in the same cycle as a clearing write wins, and the flag stays set.
- R6: With status bit 4 at 0 (level mode), `irq_n` is low exactly while the flag and status bit 0 are both set.
- R7: With status bit 4 at 1 (pulse mode), each event that occurs while status bit 0 is set drives `irq_n` low for PULSE_TICKS reference ticks. A new event during a pulse restarts the pulse.
- R8: While control bit 7 is 0, the current count holds its value and no event occurs. Setting the bit again resumes from the held value.
- R9: Unused register bits read 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
The directed part runs the timer with `ref_tick` high every cycle at the fastest rate. Under that pattern, the reload period, level mode and pulse mode can be told apart cycle for cycle. A disable/re-enable sequence tells a frozen count apart from one that keeps drifting. Writes of all-ones to each register expose reserved bits, the "write 1 keeps the flag" rule, and the read-only current count. A long random phase then mixes sparse reference ticks with writes at random times and all four rates. This catches off-by-one errors in the divider phase and in the reload, and it catches collisions between events and flag-clearing writes. Every cycle is compared against a bench model that works from a simple tick count rather than from the divider structure.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] REG_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] REG_LOAD = 2'd2;
  localparam logic [ADDR_W-1:0] REG_CUR  = 2'd3;

  localparam int unsigned STAT_IE_BIT   = 0;
  localparam int unsigned STAT_FLAG_BIT = 2;
  localparam int unsigned STAT_MODE_BIT = 4;
  localparam int unsigned CTRL_RUN_BIT  = 7;

  localparam int unsigned NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_4K  = 2'd0,
    SRC_64  = 2'd1,
    SRC_1   = 2'd2,
    SRC_MIN = 2'd3
  } tmr_src_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned TICKS_4K     = 8,
  parameter int unsigned TICKS_64     = 512,
  parameter int unsigned TICKS_1      = 32768,
  parameter int unsigned SECS_PER_MIN = 60
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_tick,
  input  logic                         run,
  input  logic                         restart,
  output logic [tmr_pkg::NUM_SRC-1:0]  tick
);
  localparam int unsigned NS = tmr_pkg::NUM_SRC;

  function automatic int unsigned stage_ratio(input int unsigned k);
    case (k)
      0:       stage_ratio = TICKS_4K;
      1:       stage_ratio = TICKS_64 / TICKS_4K;
      2:       stage_ratio = TICKS_1 / TICKS_64;
      default: stage_ratio = SECS_PER_MIN;
    endcase
  endfunction

  logic [NS:0] chain;
  assign chain[0] = ref_tick;

  for (genvar g = 0; g < NS; g++) begin : g_stage
    localparam int unsigned RAT = stage_ratio(g);
    localparam int unsigned SW  = (RAT > 2) ? $clog2(RAT) : 1;
    localparam logic [SW-1:0] LAST = SW'(RAT - 1);
    logic [SW-1:0] cnt_q;
    logic          wrap;

    assign wrap         = chain[g] && (cnt_q == LAST);
    assign chain[g + 1] = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || restart)  cnt_q <= '0;
      else if (chain[g])         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || restart) |=> (cnt_q == '0));
  end

  assign tick = chain[NS:1] & {NS{run & ~restart}};
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cur,
  output logic [W-1:0] reload,
  output logic         zero_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cur_q, rel_q;

  assign zero_evt = en && step && !load && (cur_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rel_q <= '0;
    end else if (load) begin
      cur_q <= load_val;
      rel_q <= load_val;
    end else if (en && step) begin
      if (cur_q == ONE)      cur_q <= rel_q;
      else if (cur_q != '0)  cur_q <= cur_q - ONE;
    end
  end

  assign cur    = cur_q;
  assign reload = rel_q;

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cur_q == rel_q));
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cur_q));
  assert_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && !load) |=> (cur_q == '0));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic evt,
  input  logic flag,
  input  logic ie,
  input  logic pulse_mode,
  output logic irq_n
);
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_TICKS);

  logic [PW-1:0] pcnt_q;
  logic          fire;

  assign fire = evt && ie && pulse_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pcnt_q <= '0;
    else if (fire)                     pcnt_q <= PLEN;
    else if (ref_tick && pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
  end

  assign irq_n = !((!pulse_mode && flag && ie) || (pcnt_q != '0));

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !irq_n);
  assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt_q != '0 && !ref_tick && !fire) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int unsigned TICKS_4K     = 8,
  parameter int unsigned TICKS_64     = 512,
  parameter int unsigned TICKS_1      = 32768,
  parameter int unsigned SECS_PER_MIN = 60,
  parameter int unsigned PULSE_TICKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_n
);
  logic     run_q, flag_q, ie_q, mode_q;
  tmr_src_e src_q;

  logic ctrl_wr, stat_wr, load_wr;
  logic [NUM_SRC-1:0] src_ticks;
  logic step, evt;
  logic [DW-1:0] cur, reload;

  assign ctrl_wr = reg_wr && (reg_addr == REG_CTRL);
  assign stat_wr = reg_wr && (reg_addr == REG_STAT);
  assign load_wr = reg_wr && (reg_addr == REG_LOAD);

  tmr_prescale #(
    .TICKS_4K(TICKS_4K), .TICKS_64(TICKS_64),
    .TICKS_1(TICKS_1), .SECS_PER_MIN(SECS_PER_MIN)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .run(run_q), .restart(ctrl_wr), .tick(src_ticks)
  );

  assign step = src_ticks[src_q];

  tmr_count #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(run_q), .step(step),
    .load(load_wr), .load_val(reg_wdata),
    .cur(cur), .reload(reload), .zero_evt(evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      src_q  <= SRC_4K;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q <= reg_wdata[CTRL_RUN_BIT];
        src_q <= tmr_src_e'(reg_wdata[1:0]);
      end
      if (stat_wr) begin
        ie_q   <= reg_wdata[STAT_IE_BIT];
        mode_q <= reg_wdata[STAT_MODE_BIT];
      end
      if (evt)                                     flag_q <= 1'b1;
      else if (stat_wr && !reg_wdata[STAT_FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  tmr_irq #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .evt(evt),
    .flag(flag_q), .ie(ie_q), .pulse_mode(mode_q), .irq_n(irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_STAT: begin
        reg_rdata[STAT_IE_BIT]   = ie_q;
        reg_rdata[STAT_FLAG_BIT] = flag_q;
        reg_rdata[STAT_MODE_BIT] = mode_q;
      end
      REG_CTRL: begin
        reg_rdata[CTRL_RUN_BIT] = run_q;
        reg_rdata[1:0]          = src_q;
      end
      REG_LOAD: reg_rdata = reload;
      default:  reg_rdata = cur;
    endcase
  end

  assert_evt_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_wr) |=> flag_q);
  assert_no_evt_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !evt);
  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && flag_q && ie_q) |-> !irq_n);
endmodule

// File: tb/test_tmr_countdown.sv
module test_tmr_countdown;
  localparam int unsigned T4K = 2, T64 = 8, T1 = 32, SPM = 3, PT = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic irq_n;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_countdown #(.TICKS_4K(T4K), .TICKS_64(T64), .TICKS_1(T1),
                  .SECS_PER_MIN(SPM), .PULSE_TICKS(PT)) i_tmr_countdown (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n));

  // reference model: a plain count of reference ticks since (re)start
  int m_ref, m_pulse;
  logic m_en, m_flag, m_ie, m_mode;
  logic [1:0] m_src;
  logic [7:0] m_rel, m_cur;
  logic t_ctw, t_stw, t_ldw, t_stp, t_ev;

  function automatic int period(input logic [1:0] s);
    case (s)
      2'd0: period = T4K;
      2'd1: period = T64;
      2'd2: period = T1;
      default: period = T1 * SPM;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: exp_read = {3'b0, m_mode, 1'b0, m_flag, 1'b0, m_ie};
      2'd1: exp_read = {m_en, 5'b0, m_src};
      2'd2: exp_read = m_rel;
      default: exp_read = m_cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ref = 0; m_pulse = 0; m_en = 0; m_flag = 0; m_ie = 0; m_mode = 0;
      m_src = 0; m_rel = 0; m_cur = 0;
    end else begin
      n_cyc++;
      t_ctw = reg_wr && reg_addr == 2'd1;
      t_stw = reg_wr && reg_addr == 2'd0;
      t_ldw = reg_wr && reg_addr == 2'd2;
      t_stp = m_en && !t_ctw && ref_tick && ((m_ref + 1) % period(m_src) == 0);
      t_ev = 0;
      if (t_ldw) begin m_rel = reg_wdata; m_cur = reg_wdata; end
      else if (t_stp) begin
        if (m_cur == 8'd1) begin t_ev = 1; m_cur = m_rel; end
        else if (m_cur != 8'd0) m_cur = m_cur - 8'd1;
      end
      if (t_ev && m_ie && m_mode) m_pulse = PT;
      else if (ref_tick && m_pulse > 0) m_pulse--;
      if (t_ev) m_flag = 1;
      else if (t_stw && !reg_wdata[2]) m_flag = 0;
      if (t_stw) begin m_ie = reg_wdata[0]; m_mode = reg_wdata[4]; end
      if (!m_en || t_ctw) m_ref = 0;
      else if (ref_tick) m_ref++;
      if (t_ctw) begin m_en = reg_wdata[7]; m_src = reg_wdata[1:0]; end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, n_cyc);
    end
  endtask

  task automatic compare_all();
    logic exp_irq;
    exp_irq = !((!m_mode && m_flag && m_ie) || m_pulse > 0);
    if (m_mode) check("R7 irq_n pulse", {7'b0, irq_n}, {7'b0, exp_irq});
    else        check("R6 irq_n level", {7'b0, irq_n}, {7'b0, exp_irq});
    case (reg_addr)
      2'd0: check("R4 R5 status", reg_rdata, exp_read(2'd0));
      2'd1: check("R2 control", reg_rdata, exp_read(2'd1));
      default: check("R3 count", reg_rdata, exp_read(reg_addr));
    endcase
  endtask

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d, input logic rt);
    @(negedge clk);
    compare_all();
    reg_wr = wr; reg_addr = a; reg_wdata = d; ref_tick = rt;
  endtask

  task automatic run_ref(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00, 1'b1);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    cyc(1'b0, a, 8'h00, 1'b0);
    @(negedge clk);
    v = reg_rdata;
  endtask

  always @(posedge clk) begin
    if (n_cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #0.1;
      check("R1 reset read", reg_rdata, 8'h00);
    end
    check("R1 reset irq_n", {7'b0, irq_n}, 8'h01);
    rst_n = 1'b1;

    // level mode, period 3 steps at fastest rate
    cyc(1'b1, 2'd0, 8'h01, 1'b0);
    cyc(1'b1, 2'd2, 8'd3, 1'b0);
    cyc(1'b1, 2'd1, 8'h80, 1'b0);
    run_ref(5, 2'd3);
    peek(2'd0, v);
    check("R4 flag not yet", v & 8'h04, 8'h00);
    run_ref(1, 2'd3);
    peek(2'd0, v);
    check("R4 flag set after 3 steps", v & 8'h04, 8'h04);
    check("R6 irq_n low with flag", {7'b0, irq_n}, 8'h00);
    cyc(1'b1, 2'd0, 8'h05, 1'b0);
    peek(2'd0, v);
    check("R5 write 1 keeps flag", v & 8'h04, 8'h04);
    cyc(1'b1, 2'd0, 8'h01, 1'b0);
    peek(2'd0, v);
    check("R5 write 0 clears flag", v & 8'h04, 8'h00);

    // R8: freeze while stopped
    run_ref(3, 2'd3);
    cyc(1'b1, 2'd1, 8'h00, 1'b0);
    peek(2'd3, held);
    run_ref(40, 2'd0);
    peek(2'd3, v);
    check("R8 count frozen", v, held);
    peek(2'd0, v);
    check("R8 no flag while stopped", v & 8'h04, 8'h00);

    // R9: reserved bits and read-only count
    cyc(1'b1, 2'd1, 8'h7F, 1'b0);
    peek(2'd1, v);
    check("R9 control reserved", v, 8'h03);
    cyc(1'b1, 2'd3, 8'hAA, 1'b0);
    peek(2'd3, v);
    check("R9 count read only", v, held);
    cyc(1'b1, 2'd0, 8'hFF, 1'b0);
    peek(2'd0, v);
    check("R9 status reserved", v, 8'h11);

    // R7: pulse mode, one event every 4 ref ticks
    cyc(1'b1, 2'd2, 8'd2, 1'b0);
    cyc(1'b1, 2'd1, 8'h80, 1'b0);
    run_ref(4, 2'd3);
    @(negedge clk);
    check("R7 pulse starts", {7'b0, irq_n}, 8'h00);
    run_ref(30, 2'd3);

    // R2 at each rate, plus random traffic
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 2'd2, 8'd1, 1'b0);
      cyc(1'b1, 2'd1, 8'h80 | 8'(s), 1'b0);
      run_ref(period(2'(s)) + 2, 2'(s % 2 == 0 ? 3 : 0));
    end
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic w;
      w = ($urandom % 8) == 0;
      a = 2'($urandom % 4);
      d = 8'($urandom);
      if (a == 2'd2) d = 8'($urandom % 6);
      if (a == 2'd1 && ($urandom % 4) != 0) d[7] = 1'b1;
      cyc(w, a, d, 1'($urandom % 2));
    end
    @(negedge clk);
    compare_all();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule